// File: doc/BRIEF.md
# Flash Controller Command and Interrupt Register Block

This block is the host-facing register file of a flash controller. A host reaches it over a simple synchronous bus with a valid strobe, a write flag, an address and a data word. Reads return their data one cycle after the request. The block stores eight start-address words, a start-buffer word, the command word and two configuration words. It exposes a controller status word, an interrupt status word and a fixed write-protect status word. The flash array and its error correction sit outside the block. A back-end executor reached through a start strobe and a done/error return stands in for them.

A command write is classified by its code. Load, program, erase and protection codes go to the back-end through a three-state sequencer. The states are IDLE, ISSUE and WAIT. The LAUNCH transition moves IDLE to ISSUE when a back-end command is accepted. The STROBE transition moves ISSUE to WAIT unconditionally, and one start pulse is emitted while in ISSUE. The COMPLETE transition moves WAIT to IDLE on the cycle the back-end reports done. Reset codes, the no-operation code and unknown codes are handled at once without leaving IDLE. The interrupt flag (bit 15 of interrupt status) locks out further commands until the host clears it. Clearing it also wipes the error bits. The interrupt pin's active level comes from configuration word 1.

Top module: `flash_regfile_ctl`

## Requirements
- R1: After cold reset (`rst_n` low) interrupt status reads 0x8080, configuration 1 reads 0x40C0, configuration 2, status and start-buffer read 0x0000, write-protect status reads 0x0002 and `host_rdy` is 1.
- R2: `host_irq` equals interrupt-status bit 15 XOR the inverse of configuration-1 bit 6, so configuration bit 6 = 1 makes the pin active high and 0 makes it active low.
- R3: A write to the command register (address 0x10) is ignored, leaving the stored command and sequencer unchanged, while interrupt bit 15 is set or while a command is in flight.
- R4: A write to interrupt status (0x19) ANDs the written word into it. When the resulting bit 15 is 0, status bits 13:10 are cleared; otherwise status is kept.
- R5: An accepted back-end command raises `be_start` for exactly the one cycle after the write and holds `cmd_busy` until `be_done` is seen in WAIT. A `be_done` arriving while no command is in flight has no effect.
- R6: On completion interrupt bit 15 is set together with a cause bit. Bit 7 is set for load codes 0x00 and 0x13, bit 6 for program codes 0x80, 0x1A and 0x1B, and bit 5 for erase codes 0x94, 0x95 and 0x30. Protection codes 0x23, 0x27, 0x2A, 0x2C, 0x71 and 0x65 set no cause bit. With `be_err` set, status bit 10 is set plus bit 13 (load), 12 (program) or 11 (erase).
- R7: Any code outside the listed ones sets status bit 10 and interrupt bit 15 on the next cycle without starting the back-end. Code 0xB0 is accepted and changes nothing but the stored command.
- R8: Codes 0xF0 and 0xF3 perform a warm reset. Interrupt status becomes 0x8010, configuration 1 becomes 0x40C0, and configuration 2, status, all start addresses and the command become 0. Count becomes 1, buffer address becomes 0 and `host_rdy` becomes 1.
- R9: A start-buffer write (0x08) takes the buffer address from bits 11:8 and the sector count from bits 1:0, with 0 meaning 4. A read returns the buffer address in bits 11:8 and count minus one in bits 1:0.
- R10: A read of configuration 1 (0x11) returns the stored word ANDed with 0xFFE0. Each configuration-1 write copies its bit 7 to `host_rdy`.
- R11: When a host write to interrupt status and a back-end completion fall in the same cycle, the AND and the conditional error clear are applied first and the completion bits are merged afterwards.
- R12: Addresses 0x00–0x07 are the start addresses, 0x12 configuration 2, 0x18 status and 0x1A write-protect status. Reads return on `rd_data` with `rd_vld` one cycle after the request, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| bus_vld | input | 1 | Host bus request valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 16 | Write data |
| rd_vld | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 16 | Read data |
| be_start | output | 1 | One-cycle start strobe to the back-end |
| be_cmd | output | 16 | Command code in flight |
| be_count | output | 3 | Sector count (1 to 4) |
| be_buf | output | 4 | Buffer address |
| be_saddr | output | 128 | Eight start-address words, word 0 in the low bits |
| be_done | input | 1 | Back-end completion |
| be_err | input | 1 | Back-end error, qualified by `be_done` |
| cmd_busy | output | 1 | Command in flight |
| host_irq | output | 1 | Interrupt line, polarity from configuration 1 bit 6 |
| host_rdy | output | 1 | Ready line |

## Verification
A host write to interrupt status and a back-end completion can land on the same clock edge. This is the only place where the write-to-clear path and the completion path both update interrupt status and status. The bench provokes it by launching a load and driving a write of 0x0000 to the interrupt register in the very cycle it returns done with an error. It then reads back interrupt status 0x8080 and status 0x2400. Either path winning alone would show a different word: a cleared flag, or error bits lost to the clear.

// File: rtl/flreg_pkg.sv
package flreg_pkg;

    typedef enum logic [2:0] {
        CLS_LOAD,
        CLS_PROG,
        CLS_ERASE,
        CLS_PROT,
        CLS_WRST,
        CLS_NOP,
        CLS_BAD
    } cmd_cls_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT
    } seq_state_e;

    // interrupt status bit positions
    localparam int IB_FLAG  = 15;
    localparam int IB_LOAD  = 7;
    localparam int IB_PROG  = 6;
    localparam int IB_ERASE = 5;

    // controller status bit positions
    localparam int SB_CMD   = 10;
    localparam int SB_ERASE = 11;
    localparam int SB_PROG  = 12;
    localparam int SB_LOAD  = 13;

    localparam logic [15:0] INT_COLD  = 16'h8080;
    localparam logic [15:0] INT_WARM  = 16'h8010;
    localparam logic [15:0] CFG1_INIT = 16'h40C0;
    localparam logic [15:0] WPS_VAL   = 16'h0002;
    localparam logic [15:0] CFG1_RMSK = 16'hFFE0;

    // register word addresses
    localparam logic [7:0] RA_SBUF = 8'h08;
    localparam logic [7:0] RA_CMD  = 8'h10;
    localparam logic [7:0] RA_CFG1 = 8'h11;
    localparam logic [7:0] RA_CFG2 = 8'h12;
    localparam logic [7:0] RA_STAT = 8'h18;
    localparam logic [7:0] RA_INT  = 8'h19;
    localparam logic [7:0] RA_WPS  = 8'h1A;

    function automatic cmd_cls_e classify(input logic [15:0] code);
        cmd_cls_e c;
        case (code)
            16'h0000, 16'h0013:                     c = CLS_LOAD;
            16'h0080, 16'h001A, 16'h001B:           c = CLS_PROG;
            16'h0094, 16'h0095, 16'h0030:           c = CLS_ERASE;
            16'h0023, 16'h0027, 16'h002A,
            16'h002C, 16'h0071, 16'h0065:           c = CLS_PROT;
            16'h00F0, 16'h00F3:                     c = CLS_WRST;
            16'h00B0:                               c = CLS_NOP;
            default:                                c = CLS_BAD;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/flreg_cmd_seq.sv
module flreg_cmd_seq
    import flreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [15:0] cmd_code,
    input  logic       int_pend,
    input  logic       be_done,
    input  logic       be_err,
    output logic       cmd_take,
    output logic       be_start,
    output logic       busy,
    output logic       fin,
    output cmd_cls_e   fin_cls,
    output logic       fin_err,
    output logic       wrst
);

    seq_state_e state_q, state_d;
    cmd_cls_e   cls_q, cls_in;
    logic       launch;

    assign cls_in   = classify(cmd_code);
    assign cmd_take = cmd_wr && !int_pend && (state_q == SQ_IDLE);
    assign launch   = cmd_take && (cls_in == CLS_LOAD || cls_in == CLS_PROG ||
                                   cls_in == CLS_ERASE || cls_in == CLS_PROT);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:  if (launch)  state_d = SQ_ISSUE;   // LAUNCH
            SQ_ISSUE:              state_d = SQ_WAIT;    // STROBE
            SQ_WAIT:  if (be_done) state_d = SQ_IDLE;    // COMPLETE
            default:               state_d = SQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cls_q   <= CLS_NOP;
        end else begin
            state_q <= state_d;
            if (launch) cls_q <= cls_in;
        end
    end

    // outputs
    always_comb begin
        be_start = (state_q == SQ_ISSUE);
        busy     = (state_q != SQ_IDLE);
        wrst     = cmd_take && (cls_in == CLS_WRST);
        fin      = 1'b0;
        fin_cls  = CLS_BAD;
        fin_err  = 1'b0;
        if (state_q == SQ_WAIT && be_done) begin
            fin     = 1'b1;
            fin_cls = cls_q;
            fin_err = be_err;
        end else if (cmd_take && cls_in == CLS_BAD) begin
            fin     = 1'b1;
            fin_cls = CLS_BAD;
            fin_err = 1'b1;
        end
    end

    p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        be_start |=> !be_start);

    p_busy_after_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        be_start |=> busy);

endmodule

// File: rtl/flreg_int_stat.sv
module flreg_int_stat
    import flreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wrst,
    input  logic        int_wr,
    input  logic [15:0] wdata,
    input  logic        fin,
    input  cmd_cls_e    fin_cls,
    input  logic        fin_err,
    output logic [15:0] int_q,
    output logic [15:0] stat_q
);

    localparam logic [15:0] ERR_MASK = (16'h1 << SB_CMD) | (16'h1 << SB_ERASE) |
                                       (16'h1 << SB_PROG) | (16'h1 << SB_LOAD);

    logic [15:0] masked, stat_base, set_i, set_s, int_d, stat_d;

    always_comb begin
        // host write-to-clear comes first (R11)
        masked    = int_wr ? (int_q & wdata) : int_q;
        stat_base = (int_wr && !masked[IB_FLAG]) ? (stat_q & ~ERR_MASK) : stat_q;
        set_i     = '0;
        set_s     = '0;
        if (fin) begin
            set_i[IB_FLAG] = 1'b1;
            if (fin_err) set_s[SB_CMD] = 1'b1;
            case (fin_cls)
                CLS_LOAD: begin
                    set_i[IB_LOAD] = 1'b1;
                    if (fin_err) set_s[SB_LOAD] = 1'b1;
                end
                CLS_PROG: begin
                    set_i[IB_PROG] = 1'b1;
                    if (fin_err) set_s[SB_PROG] = 1'b1;
                end
                CLS_ERASE: begin
                    set_i[IB_ERASE] = 1'b1;
                    if (fin_err) set_s[SB_ERASE] = 1'b1;
                end
                default: ;
            endcase
        end
        int_d  = masked | set_i;
        stat_d = stat_base | set_s;
        if (wrst) begin
            int_d  = INT_WARM;
            stat_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q  <= INT_COLD;
            stat_q <= '0;
        end else begin
            int_q  <= int_d;
            stat_q <= stat_d;
        end
    end

    p_err_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[SB_LOAD:SB_CMD] != 4'h0) |-> int_q[IB_FLAG]);

    p_fin_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> int_q[IB_FLAG]);

endmodule

// File: rtl/flash_regfile_ctl.sv
module flash_regfile_ctl
    import flreg_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_SADDR = 8,
    parameter int CNT_W     = 2,
    parameter int BUF_W     = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_vld,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [15:0]             bus_wdata,
    output logic                    rd_vld,
    output logic [15:0]             rd_data,
    output logic                    be_start,
    output logic [15:0]             be_cmd,
    output logic [CNT_W:0]          be_count,
    output logic [BUF_W-1:0]        be_buf,
    output logic [NUM_SADDR*16-1:0] be_saddr,
    input  logic                    be_done,
    input  logic                    be_err,
    output logic                    cmd_busy,
    output logic                    host_irq,
    output logic                    host_rdy
);

    localparam int CNT_MAX = 1 << CNT_W;

    logic wr_req, rd_req;
    logic we_cmd, we_cfg1, we_cfg2, we_sbuf, we_int;
    logic [15:0] saddr_q [NUM_SADDR];
    logic [15:0] cmd_q, cfg1_q, cfg2_q;
    logic [BUF_W-1:0] sbuf_addr_q;
    logic [CNT_W:0]   sbuf_cnt_q, cnt_d, cnt_m1;
    logic rdy_q, rd_vld_q;
    logic [15:0] rd_data_q, rd_mux;
    logic [15:0] int_q, stat_q;

    logic cmd_take, busy, fin, fin_err, wrst;
    cmd_cls_e fin_cls;

    assign wr_req  = bus_vld && bus_wr;
    assign rd_req  = bus_vld && !bus_wr;
    assign we_cmd  = wr_req && (bus_addr == ADDR_W'(RA_CMD));
    assign we_cfg1 = wr_req && (bus_addr == ADDR_W'(RA_CFG1));
    assign we_cfg2 = wr_req && (bus_addr == ADDR_W'(RA_CFG2));
    assign we_sbuf = wr_req && (bus_addr == ADDR_W'(RA_SBUF));
    assign we_int  = wr_req && (bus_addr == ADDR_W'(RA_INT));

    flreg_cmd_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (we_cmd),
        .cmd_code (bus_wdata),
        .int_pend (int_q[IB_FLAG]),
        .be_done  (be_done),
        .be_err   (be_err),
        .cmd_take (cmd_take),
        .be_start (be_start),
        .busy     (busy),
        .fin      (fin),
        .fin_cls  (fin_cls),
        .fin_err  (fin_err),
        .wrst     (wrst)
    );

    flreg_int_stat u_ist (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrst    (wrst),
        .int_wr  (we_int),
        .wdata   (bus_wdata),
        .fin     (fin),
        .fin_cls (fin_cls),
        .fin_err (fin_err),
        .int_q   (int_q),
        .stat_q  (stat_q)
    );

    // start-address words
    for (genvar g = 0; g < NUM_SADDR; g++) begin : g_saddr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                saddr_q[g] <= '0;
            else if (wrst)
                saddr_q[g] <= '0;
            else if (wr_req && bus_addr == ADDR_W'(g))
                saddr_q[g] <= bus_wdata;
        end
        assign be_saddr[g*16 +: 16] = saddr_q[g];
    end

    // start-buffer count decode: 0 selects the maximum (R9)
    assign cnt_d  = (bus_wdata[CNT_W-1:0] == '0) ? (CNT_W+1)'(CNT_MAX)
                                                : {1'b0, bus_wdata[CNT_W-1:0]};
    assign cnt_m1 = sbuf_cnt_q - (CNT_W+1)'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q       <= '0;
            cfg1_q      <= CFG1_INIT;
            cfg2_q      <= '0;
            rdy_q       <= 1'b1;
            sbuf_addr_q <= '0;
            sbuf_cnt_q  <= (CNT_W+1)'(1);
        end else if (wrst) begin
            cmd_q       <= '0;
            cfg1_q      <= CFG1_INIT;
            cfg2_q      <= '0;
            rdy_q       <= 1'b1;
            sbuf_addr_q <= '0;
            sbuf_cnt_q  <= (CNT_W+1)'(1);
        end else begin
            if (cmd_take) cmd_q <= bus_wdata;
            if (we_cfg1) begin
                cfg1_q <= bus_wdata;
                rdy_q  <= bus_wdata[7];
            end
            if (we_cfg2) cfg2_q <= bus_wdata;
            if (we_sbuf) begin
                sbuf_addr_q <= bus_wdata[8 +: BUF_W];
                sbuf_cnt_q  <= cnt_d;
            end
        end
    end

    // read path
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_SADDR; i++)
            if (bus_addr == ADDR_W'(i)) rd_mux = saddr_q[i];
        if (bus_addr == ADDR_W'(RA_SBUF))
            rd_mux = (16'(sbuf_addr_q) << 8) | 16'(cnt_m1[CNT_W-1:0]);
        if (bus_addr == ADDR_W'(RA_CMD))  rd_mux = cmd_q;
        if (bus_addr == ADDR_W'(RA_CFG1)) rd_mux = cfg1_q & CFG1_RMSK;
        if (bus_addr == ADDR_W'(RA_CFG2)) rd_mux = cfg2_q;
        if (bus_addr == ADDR_W'(RA_STAT)) rd_mux = stat_q;
        if (bus_addr == ADDR_W'(RA_INT))  rd_mux = int_q;
        if (bus_addr == ADDR_W'(RA_WPS))  rd_mux = WPS_VAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_vld_q  <= 1'b0;
            rd_data_q <= '0;
        end else begin
            rd_vld_q <= rd_req;
            if (rd_req) rd_data_q <= rd_mux;
        end
    end

    assign rd_vld   = rd_vld_q;
    assign rd_data  = rd_data_q;
    assign be_cmd   = cmd_q;
    assign be_count = sbuf_cnt_q;
    assign be_buf   = sbuf_addr_q;
    assign cmd_busy = busy;
    assign host_rdy = rdy_q;
    assign host_irq = int_q[IB_FLAG] ^ ~cfg1_q[6];   // R2

    p_cmd_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we_cmd && (int_q[IB_FLAG] || busy)) |=> $stable(cmd_q));

    p_rdy_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        we_cfg1 |=> (host_rdy == $past(bus_wdata[7])));

endmodule

// File: tb/flash_regfile_ctl_tb_top.sv
module flash_regfile_ctl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_vld = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        rd_vld;
    logic [15:0] rd_data;
    logic        be_start;
    logic [15:0] be_cmd;
    logic [2:0]  be_count;
    logic [3:0]  be_buf;
    logic [127:0] be_saddr;
    logic        be_done = 1'b0;
    logic        be_err = 1'b0;
    logic        cmd_busy, host_irq, host_rdy;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    flash_regfile_ctl dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_vld(bus_vld), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_vld(rd_vld), .rd_data(rd_data),
        .be_start(be_start), .be_cmd(be_cmd), .be_count(be_count), .be_buf(be_buf),
        .be_saddr(be_saddr), .be_done(be_done), .be_err(be_err),
        .cmd_busy(cmd_busy), .host_irq(host_irq), .host_rdy(host_rdy)
    );

    // op codes: 0 write, 1 read+check, 2 done pulse (err=val[0]),
    //           3 check irq, 4 check rdy, 5 check busy, 6 check start
    localparam int NV = 64;
    localparam logic [30:0] VEC [NV] = '{
        {3'd1, 4'd1,  8'h19, 16'h8080},  // R1 cold interrupt status
        {3'd1, 4'd1,  8'h11, 16'h40C0},  // R1 cfg1
        {3'd1, 4'd1,  8'h12, 16'h0000},  // R1 cfg2
        {3'd1, 4'd1,  8'h18, 16'h0000},  // R1 status
        {3'd1, 4'd1,  8'h08, 16'h0000},  // R1 start buffer
        {3'd1, 4'd1,  8'h1A, 16'h0002},  // R1 write-protect
        {3'd4, 4'd1,  8'h00, 16'h0001},  // R1 rdy
        {3'd3, 4'd2,  8'h00, 16'h0001},  // R2 irq active high, flag set
        {3'd0, 4'd3,  8'h10, 16'h0080},  // R3 command while flag set
        {3'd1, 4'd3,  8'h10, 16'h0000},  // R3 ignored
        {3'd5, 4'd3,  8'h00, 16'h0000},  // R3 not busy
        {3'd0, 4'd4,  8'h19, 16'h7FFF},  // R4 clear flag
        {3'd1, 4'd4,  8'h19, 16'h0080},  // R4
        {3'd3, 4'd2,  8'h00, 16'h0000},  // R2
        {3'd0, 4'd9,  8'h08, 16'h0A02},  // R9
        {3'd1, 4'd9,  8'h08, 16'h0A01},  // R9
        {3'd0, 4'd9,  8'h08, 16'h0300},  // R9 zero count means 4
        {3'd1, 4'd9,  8'h08, 16'h0303},  // R9
        {3'd0, 4'd10, 8'h11, 16'h40FF},  // R10
        {3'd1, 4'd10, 8'h11, 16'h40E0},  // R10 masked read
        {3'd4, 4'd10, 8'h00, 16'h0001},  // R10 rdy
        {3'd0, 4'd10, 8'h11, 16'h4040},  // R10
        {3'd4, 4'd10, 8'h00, 16'h0000},  // R10 rdy low
        {3'd1, 4'd10, 8'h11, 16'h4040},  // R10
        {3'd0, 4'd5,  8'h10, 16'h0013},  // R5 load launch
        {3'd6, 4'd5,  8'h00, 16'h0001},  // R5 start
        {3'd5, 4'd5,  8'h00, 16'h0001},  // R5 busy
        {3'd1, 4'd12, 8'h10, 16'h0013},  // R12 command readback
        {3'd6, 4'd5,  8'h00, 16'h0000},  // R5 start one cycle
        {3'd2, 4'd6,  8'h00, 16'h0000},  // R6 done ok
        {3'd5, 4'd5,  8'h00, 16'h0000},  // R5 busy drops
        {3'd1, 4'd6,  8'h19, 16'h8080},  // R6 load cause
        {3'd3, 4'd2,  8'h00, 16'h0001},  // R2
        {3'd0, 4'd4,  8'h19, 16'h0000},  // R4
        {3'd0, 4'd6,  8'h10, 16'h0080},  // R6 program
        {3'd2, 4'd6,  8'h00, 16'h0001},  // R6 done err
        {3'd1, 4'd6,  8'h18, 16'h1400},  // R6
        {3'd1, 4'd6,  8'h19, 16'h8040},  // R6
        {3'd0, 4'd4,  8'h19, 16'hFFFF},  // R4 flag stays
        {3'd1, 4'd4,  8'h18, 16'h1400},  // R4 errors kept
        {3'd0, 4'd4,  8'h19, 16'h0040},  // R4 flag cleared
        {3'd1, 4'd4,  8'h18, 16'h0000},  // R4 errors wiped
        {3'd0, 4'd2,  8'h11, 16'h0000},  // R2 active low
        {3'd3, 4'd2,  8'h00, 16'h0001},  // R2
        {3'd0, 4'd2,  8'h11, 16'h40C0},  // R2
        {3'd3, 4'd2,  8'h00, 16'h0000},  // R2
        {3'd0, 4'd7,  8'h10, 16'h0055},  // R7 unknown
        {3'd1, 4'd7,  8'h18, 16'h0400},  // R7
        {3'd1, 4'd7,  8'h19, 16'h8040},  // R7
        {3'd5, 4'd7,  8'h00, 16'h0000},  // R7 no launch
        {3'd0, 4'd4,  8'h19, 16'h0000},  // R4
        {3'd0, 4'd6,  8'h10, 16'h0094},  // R6 erase
        {3'd2, 4'd6,  8'h00, 16'h0001},  // R6
        {3'd1, 4'd6,  8'h18, 16'h0C00},  // R6
        {3'd1, 4'd6,  8'h19, 16'h8020},  // R6
        {3'd0, 4'd4,  8'h19, 16'h0000},  // R4
        {3'd0, 4'd6,  8'h10, 16'h0023},  // R6 protection
        {3'd2, 4'd6,  8'h00, 16'h0000},  // R6
        {3'd1, 4'd6,  8'h19, 16'h8000},  // R6 no cause bit
        {3'd0, 4'd4,  8'h19, 16'h0000},  // R4
        {3'd0, 4'd5,  8'h10, 16'h0000},  // R5 load
        {3'd0, 4'd3,  8'h10, 16'h0080},  // R3 while busy
        {3'd1, 4'd3,  8'h10, 16'h0000},  // R3 ignored
        {3'd2, 4'd6,  8'h00, 16'h0000}   // R6
    };

    task automatic check(input int req, input logic [15:0] got, input logic [15:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL R%0d: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_vld = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_vld = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_vld = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_vld = 1'b0;
        d = rd_data;
    endtask

    task automatic read_chk(input int req, input logic [7:0] a, input logic [15:0] exp);
        logic [15:0] got;
        bus_read(a, got);
        check(req, got, exp);
    endtask

    task automatic pulse_done(input logic e);
        @(negedge clk);
        @(negedge clk);
        be_done = 1'b1; be_err = e;
        @(posedge clk); #1;
        be_done = 1'b0; be_err = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            automatic logic [2:0]  op  = VEC[i][30:28];
            automatic int          req = int'(VEC[i][27:24]);
            automatic logic [7:0]  a   = VEC[i][23:16];
            automatic logic [15:0] v   = VEC[i][15:0];
            case (op)
                3'd0: bus_write(a, v);
                3'd1: read_chk(req, a, v);
                3'd2: pulse_done(v[0]);
                3'd3: check(req, {15'b0, host_irq}, v);
                3'd4: check(req, {15'b0, host_rdy}, v);
                3'd5: check(req, {15'b0, cmd_busy}, v);
                default: check(req, {15'b0, be_start}, v);
            endcase
        end

        // R8 warm reset by command
        bus_write(8'h19, 16'h0000);
        bus_write(8'h03, 16'h1234);
        read_chk(12, 8'h03, 16'h1234);          // R12 start address
        bus_write(8'h12, 16'hBEEF);
        read_chk(12, 8'h12, 16'hBEEF);          // R12 cfg2
        bus_write(8'h08, 16'h0502);
        check(9, {13'b0, be_count}, 16'h0002);  // R9 count to back-end
        check(9, {12'b0, be_buf}, 16'h0005);    // R9 buffer to back-end
        bus_write(8'h11, 16'h0000);
        bus_write(8'h10, 16'h00F3);
        read_chk(8, 8'h19, 16'h8010);           // R8
        read_chk(8, 8'h03, 16'h0000);
        read_chk(8, 8'h12, 16'h0000);
        read_chk(8, 8'h08, 16'h0000);
        read_chk(8, 8'h11, 16'h40C0);
        read_chk(8, 8'h10, 16'h0000);
        read_chk(8, 8'h18, 16'h0000);
        check(8, {15'b0, host_rdy}, 16'h0001);

        // R5 stray done while idle is ignored
        pulse_done(1'b1);
        read_chk(5, 8'h19, 16'h8010);
        read_chk(5, 8'h18, 16'h0000);

        // R7 no-operation code
        bus_write(8'h19, 16'h0000);
        bus_write(8'h10, 16'h00B0);
        read_chk(7, 8'h10, 16'h00B0);
        read_chk(7, 8'h19, 16'h0000);
        check(7, {15'b0, cmd_busy}, 16'h0000);

        // R11 clear write and completion on the same edge
        bus_write(8'h10, 16'h0000);
        @(negedge clk);
        @(negedge clk);
        bus_vld = 1'b1; bus_wr = 1'b1; bus_addr = 8'h19; bus_wdata = 16'h0000;
        be_done = 1'b1; be_err = 1'b1;
        @(posedge clk); #1;
        bus_vld = 1'b0; bus_wr = 1'b0; be_done = 1'b0; be_err = 1'b0;
        read_chk(11, 8'h19, 16'h8080);
        read_chk(11, 8'h18, 16'h2400);

        // R12 unmapped address and read latency
        read_chk(12, 8'h3F, 16'h0000);
        check(12, {15'b0, rd_vld}, 16'h0001);
        @(posedge clk); #1;
        check(12, {15'b0, rd_vld}, 16'h0000);

        // R1 cold reset after activity
        bus_write(8'h11, 16'h0000);
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(1, {15'b0, host_rdy}, 16'h0001);
        read_chk(1, 8'h11, 16'h40C0);
        read_chk(1, 8'h19, 16'h8080);
        read_chk(1, 8'h18, 16'h0000);

        finished = 1'b1;
        finish_run();
    end

endmodule